// File: doc/BRIEF.md
# Serial Synthesizer Control Word Loader

This block writes one 40-bit configuration word into a frequency synthesizer over three wires: a serial data line, a bit clock and an update strobe. A start pulse captures four fields: a 32-bit tuning value, a clock-multiplier enable, a power-down flag and a 5-bit phase code. The block packs them into the word and sends it least significant bit first, with one bit-clock pulse per bit. It then raises the update strobe once, so the receiver applies the new settings together, and flags completion.

All serial timing is built from a divided tick. The tick period is `div_i + 1` system clocks, and `div_i` is captured at start. Each bit takes three ticks: setup, clock high and clock low. The update strobe lasts one tick. A whole transfer takes `121 * (div_i + 1) + 1` clocks from the start edge to the done pulse.

Top module: `cwl_loader`

## Requirements
- R1: Word layout: bits 31..0 carry `tune_i`, bit 32 carries `mult_en_i`, bit 33 is always 0, bit 34 carries `pdown_i`, bits 39..35 carry `phase_i`.
- R2: Each transfer gives exactly 40 `bit_clk_o` pulses. Bit 0 is presented first and bit 39 last, and `ser_data_o` is sampled on each rising edge.
- R3: `ser_data_o` is stable for at least one tick before each `bit_clk_o` rising edge. It stays unchanged through the high phase and the falling edge.
- R4: Each `bit_clk_o` high phase lasts exactly `div+1` clocks. Consecutive pulses in a transfer are separated by exactly `2*(div+1)` low clocks.
- R5: One `update_o` pulse of exactly `div+1` clocks follows the last bit-clock fall. It never overlaps `bit_clk_o`.
- R6: `done_o` is high for exactly one clock, in the clock right after `update_o` falls.
- R7: A `start_i` pulse while a transfer is in progress is ignored. No extra word and no extra update is produced.
- R8: During reset and while idle, `bit_clk_o`, `update_o`, `done_o` and `ser_data_o` are low.
- R9: `div_i` and the field inputs are sampled only on an accepted start. Changing them mid-transfer does not alter timing or content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (honoured when idle) |
| tune_i | input | 32 | Tuning value |
| mult_en_i | input | 1 | Clock-multiplier enable |
| pdown_i | input | 1 | Power-down flag |
| phase_i | input | 5 | Phase code |
| div_i | input | DIV_W | Tick period minus one, in clocks |
| ser_data_o | output | 1 | Serial data |
| bit_clk_o | output | 1 | Per-bit clock pulse |
| update_o | output | 1 | Apply-settings strobe |
| done_o | output | 1 | One-clock completion pulse |

## Verification
Words are sent with alternating bit patterns, all fields set to ones, all fields set to zero, and a mixed value. Matching the reconstructed words separates a correct layout from swapped fields, reversed bit order and a set reserved bit. Dividers of 0, 1, 3 and 6 separate correct tick timing from off-by-one widths and gaps. A mid-transfer start with new fields and a new divider separates proper input capture from re-triggering or live sampling.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  localparam int TUNE_W  = 32;
  localparam int PHASE_W = 5;
  localparam int WORD_W  = TUNE_W + 3 + PHASE_W;
  localparam int CNT_W   = $clog2(WORD_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HIGH, ST_LOW, ST_UPD, ST_DONE
  } state_e;

  function automatic logic [WORD_W-1:0] pack_word(
    input logic [TUNE_W-1:0]  tune,
    input logic               mult,
    input logic               pdown,
    input logic [PHASE_W-1:0] phase
  );
    return {phase, pdown, 1'b0, mult, tune};
  endfunction
endpackage

// File: rtl/cwl_tick.sv
module cwl_tick #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (cnt_q == lim_i)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == lim_i);

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0) else $error("AST_CNT_RESTART"); // R4
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $stable(lim_i) |-> cnt_q <= lim_i) else $error("AST_CNT_BOUND"); // R4
endmodule

// File: rtl/cwl_shreg.sv
module cwl_shreg #(
  parameter int W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         lsb_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= data_i;
    else if (shift_i) q <= {1'b0, q[W-1:1]};
  end

  assign lsb_o = q[0];

  AST_SHIFT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && !load_i |=> lsb_o == $past(q[1])) else $error("AST_SHIFT_ORDER"); // R2
endmodule

// File: rtl/cwl_loader.sv
module cwl_loader
  import cwl_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [TUNE_W-1:0]   tune_i,
  input  logic                mult_en_i,
  input  logic                pdown_i,
  input  logic [PHASE_W-1:0]  phase_i,
  input  logic [DIV_W-1:0]    div_i,
  output logic                ser_data_o,
  output logic                bit_clk_o,
  output logic                update_o,
  output logic                done_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  state_e             state_q;
  logic [CNT_W-1:0]   bit_q;
  logic [DIV_W-1:0]   div_q;
  logic               tick, tick_en, load, shift, lsb;

  assign load    = (state_q == ST_IDLE) && start_i;
  assign tick_en = (state_q == ST_SETUP) || (state_q == ST_HIGH) ||
                   (state_q == ST_LOW)   || (state_q == ST_UPD);
  assign shift   = tick && (state_q == ST_LOW) && (bit_q != LAST_BIT);

  cwl_tick #(.W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .en_i(tick_en), .lim_i(div_q), .tick_o(tick)
  );

  cwl_shreg #(.W(WORD_W)) u_shreg (
    .clk_i, .rst_ni, .load_i(load),
    .data_i(pack_word(tune_i, mult_en_i, pdown_i, phase_i)),
    .shift_i(shift), .lsb_o(lsb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      div_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          div_q   <= div_i;
          bit_q   <= '0;
          state_q <= ST_SETUP;
        end
        ST_SETUP: if (tick) state_q <= ST_HIGH;
        ST_HIGH:  if (tick) state_q <= ST_LOW;
        ST_LOW: if (tick) begin
          if (bit_q == LAST_BIT) state_q <= ST_UPD;
          else begin
            bit_q   <= bit_q + 1'b1;
            state_q <= ST_SETUP;
          end
        end
        ST_UPD:  if (tick) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bit_clk_o  = (state_q == ST_HIGH);
  assign update_o   = (state_q == ST_UPD);
  assign done_o     = (state_q == ST_DONE);
  assign ser_data_o = lsb && ((state_q == ST_SETUP) || (state_q == ST_HIGH) ||
                              (state_q == ST_LOW));

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_clk_o |-> $stable(ser_data_o)) else $error("AST_DATA_HOLD"); // R3
  AST_DATA_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bit_clk_o) |-> $stable(ser_data_o)) else $error("AST_DATA_FALL"); // R3
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_clk_o && update_o)) else $error("AST_NO_OVERLAP"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("AST_DONE_PULSE"); // R6
  AST_DONE_AFTER_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(update_o)) else $error("AST_DONE_AFTER_UPD"); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !bit_clk_o && !update_o && !ser_data_o)
    else $error("AST_IDLE_QUIET"); // R8
  AST_BIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= LAST_BIT) else $error("AST_BIT_BOUND"); // R2
  AST_DIV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_IDLE |=> $stable(div_q)) else $error("AST_DIV_HELD"); // R9
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && tick_en |=> state_q != ST_IDLE) else $error("AST_START_IGNORED"); // R7
endmodule

// File: tb/cwl_loader_test.sv
module cwl_loader_test;
  localparam int DIV_W = 16;

  logic        clk_i = 0, rst_ni = 0, start_i = 0;
  logic [31:0] tune_i = '0;
  logic        mult_en_i = 0, pdown_i = 0;
  logic [4:0]  phase_i = '0;
  logic [DIV_W-1:0] div_i = '0;
  logic ser_data_o, bit_clk_o, update_o, done_o;

  always #5 clk_i = ~clk_i;

  cwl_loader #(.DIV_W(DIV_W)) uut (.*);

  typedef struct { logic [39:0] word; int div; } item_t;
  item_t exp_q[$];

  int n_checks = 0, n_errors = 0, n_frames = 0, n_sent = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor state
  logic [39:0] recon;
  int bit_idx = 0, hi_run = 0, lo_run = 0, up_run = 0, scnt = 0;
  bit seen_pulse = 0;
  logic pb = 0, pu = 0, pd = 0, pdat = 0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      int d;
      d = (exp_q.size() > 0) ? exp_q[0].div : 0;
      if (ser_data_o == pdat) scnt++; else scnt = 0;
      if (bit_clk_o && !pb) begin
        chk(exp_q.size() > 0, "R7 pulse without start", 0, 1);
        chk(scnt >= d + 1, "R3 setup", scnt, d + 1);
        if (seen_pulse) chk(lo_run == 2 * (d + 1), "R4 gap", lo_run, 2 * (d + 1));
        if (bit_idx < 40) recon[bit_idx] = ser_data_o;
        bit_idx++;
        hi_run = 1;
        seen_pulse = 1;
      end else if (bit_clk_o) begin
        hi_run++;
        if (ser_data_o != pdat) chk(0, "R3 hold high", ser_data_o, pdat);
      end else if (pb) begin
        chk(hi_run == d + 1, "R4 width", hi_run, d + 1);
        chk(ser_data_o == pdat, "R3 hold fall", ser_data_o, pdat);
        lo_run = 1;
      end else lo_run++;
      if (update_o && !pu) begin
        chk(bit_idx == 40, "R2 pulse count", bit_idx, 40);
        if (exp_q.size() > 0)
          chk(recon == exp_q[0].word, "R1 word", recon, exp_q[0].word);
        chk(!bit_clk_o, "R5 overlap", bit_clk_o, 0);
        up_run = 1;
      end else if (update_o) begin
        up_run++;
        if (bit_clk_o) chk(0, "R5 overlap", 1, 0);
      end else if (pu) begin
        chk(up_run == d + 1, "R5 width", up_run, d + 1);
        chk(done_o == 1'b1, "R6 done after update", done_o, 1);
      end
      if (pd) chk(!done_o, "R6 done one cycle", done_o, 0);
      if (done_o && !pd) begin
        chk(pu, "R6 done follows update", pu, 1);
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        n_frames++;
        bit_idx = 0;
        seen_pulse = 0;
      end
      pb = bit_clk_o; pu = update_o; pd = done_o; pdat = ser_data_o;
    end
  end

  task automatic send(input logic [31:0] t, input logic m, input logic p,
                      input logic [4:0] ph, input int d);
    item_t it;
    @(negedge clk_i);
    tune_i = t; mult_en_i = m; pdown_i = p; phase_i = ph; div_i = DIV_W'(d);
    start_i = 1;
    it.word = {ph, p, 1'b0, m, t};   // R1 layout
    it.div = d;
    exp_q.push_back(it);
    n_sent++;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic wait_done();
    @(posedge done_o);
    repeat (3) @(negedge clk_i);
    chk(!bit_clk_o && !update_o && !ser_data_o && !done_o, "R8 idle quiet",
        {bit_clk_o, update_o, ser_data_o, done_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk({ser_data_o, bit_clk_o, update_o, done_o} == 4'b0, "R8 reset state",
        {ser_data_o, bit_clk_o, update_o, done_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    chk({ser_data_o, bit_clk_o, update_o, done_o} == 4'b0, "R8 after reset",
        {ser_data_o, bit_clk_o, update_o, done_o}, 0);

    send(32'hA5A5_5A5A, 1, 0, 5'h15, 0);  wait_done();
    send(32'hFFFF_FFFF, 1, 1, 5'h1F, 1);  wait_done();
    send(32'h0000_0000, 0, 0, 5'h00, 3);  wait_done();
    send(32'h1234_5678, 0, 1, 5'h0A, 6);  wait_done();

    // R7 R9: new start, fields and divider mid-transfer
    send(32'h8000_0001, 1, 0, 5'h11, 2);
    repeat (60) @(negedge clk_i);
    tune_i = 32'h0F0F_0F0F; mult_en_i = 0; pdown_i = 1; phase_i = 5'h0E; div_i = 5;
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    wait_done();
    repeat (400) @(negedge clk_i);
    chk(n_frames == n_sent, "R7 frame count", n_frames, n_sent);
    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_frames, n_sent);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule